// File: doc/BRIEF.md
# Cursor Blink and Scan-Line Gate

This block decides, for every scan line of a text display, whether the cursor shape is painted. A short setup sequence configures it: a command strobe followed by up to three parameter bytes. Those bytes set the enable bit, the row height, the cursor's first and last line within a character row, a steady-or-blinking choice and a 5-bit blink rate.

A frame strobe advances a blink counter once per video frame. When the counter reaches twice the programmed rate, it clears and a two-bit blink phase steps forward. The display pipeline presents the current line number within the character row. One clock later, the block answers with a registered draw flag. Generating the character pattern and comparing the cursor address are handled elsewhere.

Top module: `cursor_blink_gen`

## Requirements
- R1: After synchronous reset the blink phase is 0, the blink counter is 0, the cursor is enabled and blinking, the effective period is 64 frames, the top line is 0, the bottom line is 15 and `row_last` is 15.
- R2: The first parameter byte after `cmd_start` sets the enable bit from bit 7 and `row_last` from bits 4:0. Both take effect in the cycle after the byte is accepted.
- R3: The second byte is only held. When the third byte arrives, the top line takes byte2[4:0], steady mode takes byte2[5], the bottom line takes byte3[7:3] and the blink rate BR takes {byte3[2:0], byte2[7:6]}. Until the third byte arrives, the previous values stay in force.
- R4: The effective period is 2×BR frames, and a BR of 0 counts as 32. Each frame tick increments the counter. When the incremented value equals the period, the counter clears and the phase advances.
- R5: The phase advances by exactly one, wraps from 3 to 0, and changes only on a frame tick.
- R6: If the incremented counter reaches 64 without equalling the period, it clears and the phase does not advance.
- R7: A blinking cursor is visible in phases 0 and 1 and hidden in phases 2 and 3. A steady cursor is visible in every phase.
- R8: `cursor_draw` is registered. It is 1 in the cycle after a clock edge at which the enable bit was set, `row_line` lay between the top and bottom lines inclusive, and the cursor was visible.
- R9: Parameter bytes after the third are ignored until the next `cmd_start`.
- R10: A parameter byte presented in the same cycle as `cmd_start` is ignored, and the sequence restarts at the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Starts a setup sequence |
| prm_valid | input | 1 | Parameter byte strobe |
| prm_data | input | 8 | Parameter byte |
| frame_tick | input | 1 | One pulse per video frame |
| row_line | input | 5 | Scan line number within the character row |
| cursor_draw | output | 1 | Cursor painted on this line (registered) |
| blink_phase | output | 2 | Current blink phase |
| row_last | output | 5 | Lines per row minus one |

## Verification
The bench builds the block with its default parameters: 5-bit line numbers and a 5-bit blink rate, which give a 7-bit counter. With these values the zero-as-32 rule, the 64-frame period and the bit-6 overflow clear can all be reached within a few hundred frame ticks. The overflow case is driven by lowering the rate while the counter sits above the new period, so the counter runs on to 64 and clears without advancing the phase. A behavioural model tracks the draw flag, the phase and the row height, and is compared against the outputs on every clock.

// File: rtl/cursor_blink_pkg.sv
package cursor_blink_pkg;
  typedef enum logic [1:0] {
    SEQ_B1   = 2'd0,
    SEQ_B2   = 2'd1,
    SEQ_B3   = 2'd2,
    SEQ_DONE = 2'd3
  } seq_e;

  typedef struct packed {
    logic       en;
    logic       steady;
    logic [4:0] top;
    logic [4:0] bot;
  } shape_t;
endpackage

// File: rtl/cursor_cfg_seq.sv
module cursor_cfg_seq
  import cursor_blink_pkg::*;
#(
  parameter int LINE_W = 5,
  parameter int BR_W   = 5,
  localparam int CNT_W = BR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              prm_valid,
  input  logic [7:0]        prm_data,
  output logic              en,
  output logic              steady,
  output logic [LINE_W-1:0] top,
  output logic [LINE_W-1:0] bot,
  output logic [LINE_W-1:0] row_last,
  output logic [CNT_W-1:0]  period
);
  localparam int BR_LO = 2;
  localparam int BR_HI = BR_W - BR_LO;
  localparam logic [BR_W:0] BR_ZERO_MAP = (BR_W+1)'(1) << BR_W;

  seq_e       step;
  logic [7:0] held_b2;
  logic [BR_W-1:0] br_raw;
  logic [BR_W:0]   br_eff;

  assign br_raw = {prm_data[BR_HI-1:0], held_b2[7:8-BR_LO]};
  assign br_eff = (br_raw == '0) ? BR_ZERO_MAP : {1'b0, br_raw};

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= SEQ_B1;
      held_b2  <= '0;
      en       <= 1'b1;
      steady   <= 1'b0;
      top      <= '0;
      bot      <= LINE_W'(15);
      row_last <= LINE_W'(15);
      period   <= {BR_ZERO_MAP, 1'b0};
    end else if (cmd_start) begin
      step <= SEQ_B1;
    end else if (prm_valid) begin
      case (step)
        SEQ_B1: begin
          en       <= prm_data[7];
          row_last <= prm_data[LINE_W-1:0];
          step     <= SEQ_B2;
        end
        SEQ_B2: begin
          held_b2 <= prm_data;
          step    <= SEQ_B3;
        end
        SEQ_B3: begin
          top    <= held_b2[LINE_W-1:0];
          steady <= held_b2[5];
          bot    <= prm_data[7:8-LINE_W];
          period <= {br_eff, 1'b0};
          step   <= SEQ_DONE;
        end
        default: step <= SEQ_DONE;
      endcase
    end
  end

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (step == SEQ_DONE && !cmd_start) |=> step == SEQ_DONE);
  a_r10_start_wins: assert property (@(posedge clk) disable iff (rst)
    cmd_start |=> step == SEQ_B1);
  a_r4_period_nonzero: assert property (@(posedge clk) disable iff (rst)
    period != '0 && period[0] == 1'b0);
endmodule

// File: rtl/cursor_blink_timer.sv
module cursor_blink_timer #(
  parameter int BR_W   = 5,
  localparam int CNT_W = BR_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic [CNT_W-1:0] period,
  output logic [1:0]       phase
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (frame_tick) begin
      if (cnt_inc == period) begin
        cnt   <= '0;
        phase <= phase + 2'd1;
      end else if (cnt_inc[CNT_W-1]) begin
        cnt <= '0;
      end else begin
        cnt <= cnt_inc;
      end
    end
  end

  a_r5_phase_only_on_tick: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(phase));
  a_r5_phase_single_step: assert property (@(posedge clk) disable iff (rst)
    (phase != $past(phase)) |-> (phase == $past(phase) + 2'd1));
  a_r6_cnt_below_top: assert property (@(posedge clk) disable iff (rst)
    cnt[CNT_W-1] == 1'b0);
endmodule

// File: rtl/cursor_line_gate.sv
module cursor_line_gate
  import cursor_blink_pkg::*;
#(
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              steady,
  input  logic [LINE_W-1:0] top,
  input  logic [LINE_W-1:0] bot,
  input  logic [1:0]        phase,
  input  logic [LINE_W-1:0] row_line,
  output logic              draw
);
  logic in_range;
  logic visible;

  assign in_range = (row_line >= top) && (row_line <= bot);
  assign visible  = steady || !phase[1];

  always_ff @(posedge clk) begin
    if (rst) draw <= 1'b0;
    else     draw <= en && in_range && visible;
  end

  a_r8_disabled_no_draw: assert property (@(posedge clk) disable iff (rst)
    !en |=> !draw);
  a_r7_hidden_phase: assert property (@(posedge clk) disable iff (rst)
    (!steady && phase[1]) |=> !draw);
  a_r8_below_top: assert property (@(posedge clk) disable iff (rst)
    (row_line < top) |=> !draw);
endmodule

// File: rtl/cursor_blink_gen.sv
module cursor_blink_gen
  import cursor_blink_pkg::*;
#(
  parameter int LINE_W = 5,
  parameter int BR_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              prm_valid,
  input  logic [7:0]        prm_data,
  input  logic              frame_tick,
  input  logic [LINE_W-1:0] row_line,
  output logic              cursor_draw,
  output logic [1:0]        blink_phase,
  output logic [LINE_W-1:0] row_last
);
  localparam int CNT_W = BR_W + 2;

  shape_t           shape;
  logic [CNT_W-1:0] period;

  cursor_cfg_seq #(.LINE_W(LINE_W), .BR_W(BR_W)) u_cfg (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .prm_valid(prm_valid),
    .prm_data(prm_data), .en(shape.en), .steady(shape.steady),
    .top(shape.top), .bot(shape.bot), .row_last(row_last), .period(period)
  );

  cursor_blink_timer #(.BR_W(BR_W)) u_timer (
    .clk(clk), .rst(rst), .frame_tick(frame_tick), .period(period),
    .phase(blink_phase)
  );

  cursor_line_gate #(.LINE_W(LINE_W)) u_gate (
    .clk(clk), .rst(rst), .en(shape.en), .steady(shape.steady),
    .top(shape.top), .bot(shape.bot), .phase(blink_phase),
    .row_line(row_line), .draw(cursor_draw)
  );
endmodule

// File: tb/tb_cursor_blink_gen.sv
module tb_cursor_blink_gen;
  logic clk = 0;
  logic rst = 1;
  logic cmd_start = 0, prm_valid = 0, frame_tick = 0;
  logic [7:0] prm_data = 0;
  logic [4:0] row_line = 0;
  logic cursor_draw;
  logic [1:0] blink_phase;
  logic [4:0] row_last;

  int tests = 0, fails = 0;

  cursor_blink_gen dut (.*);

  always #5 clk = ~clk;

  // behavioural reference
  int m_en, m_steady, m_top, m_bot, m_last, m_rate, m_cnt, m_phase, m_idx, m_b2;
  int e_draw;
  bit m_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 1; m_steady = 0; m_top = 0; m_bot = 15; m_last = 15;
      m_rate = 64; m_cnt = 0; m_phase = 0; m_idx = 0; m_b2 = 0; e_draw = 0;
      m_live = 1;
    end else begin
      e_draw = (m_en != 0 && row_line >= m_top && row_line <= m_bot &&
                (m_steady != 0 || m_phase < 2)) ? 1 : 0;
      if (frame_tick) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == m_rate) begin m_cnt = 0; m_phase = (m_phase + 1) % 4; end
        else if (m_cnt >= 64) m_cnt = 0;
      end
      if (cmd_start) m_idx = 0;
      else if (prm_valid) begin
        if (m_idx == 0) begin m_en = prm_data[7]; m_last = prm_data & 31; m_idx = 1; end
        else if (m_idx == 1) begin m_b2 = prm_data; m_idx = 2; end
        else if (m_idx == 2) begin
          int br;
          m_top = m_b2 & 31; m_steady = (m_b2 >> 5) & 1; m_bot = prm_data >> 3;
          br = ((prm_data & 7) << 2) | (m_b2 >> 6);
          if (br == 0) br = 32;
          m_rate = 2 * br; m_idx = 3;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && m_live) begin
      check(cursor_draw == e_draw, "R8 draw vs model", cursor_draw, e_draw);
      check(blink_phase == m_phase, "R5 phase vs model", blink_phase, m_phase);
      check(row_last == m_last, "R2 row_last vs model", row_last, m_last);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_cmd();
    cmd_start = 1; cyc(1); cmd_start = 0;
  endtask

  task automatic prm(input logic [7:0] d);
    prm_valid = 1; prm_data = d; cyc(1); prm_valid = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin frame_tick = 1; cyc(1); frame_tick = 0; cyc(1); end
  endtask

  task automatic draw_at(input int row, input int exp, input string tag);
    row_line = 5'(row); cyc(1);
    check(cursor_draw == exp, tag, cursor_draw, exp);
  endtask

  task automatic do_reset();
    rst = 1; cyc(2); rst = 0; cyc(1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        do_reset();
        check(blink_phase == 0, "R1 reset phase", blink_phase, 0);
        check(row_last == 15, "R1 reset row_last", row_last, 15);
        draw_at(5, 1, "R1 reset draw in range");
        draw_at(20, 0, "R8 row beyond bottom");
        // program: enable, 8 lines, blink, top 2, bottom 5, BR=1
        start_cmd();
        prm(8'h87); cyc(1);
        check(row_last == 7, "R2 row_last from byte1", row_last, 7);
        prm(8'h42);
        draw_at(0, 1, "R3 old top until byte3");
        prm(8'h28);
        draw_at(1, 0, "R3 new top applied");
        draw_at(3, 1, "R3 inside new range");
        draw_at(6, 0, "R3 new bottom applied");
        row_line = 3;
        ticks(2);
        check(blink_phase == 1, "R4 period 2 frames", blink_phase, 1);
        ticks(2);
        check(blink_phase == 2, "R4 second step", blink_phase, 2);
        draw_at(3, 0, "R7 hidden in phase 2");
        ticks(4);
        check(blink_phase == 0, "R5 wrap to zero", blink_phase, 0);
        prm(8'h00); cyc(1);
        check(row_last == 7, "R9 extra byte ignored", row_last, 7);
        draw_at(3, 1, "R9 enable kept");
        // steady
        start_cmd(); prm(8'h87); prm(8'h62); prm(8'h28);
        ticks(4);
        draw_at(3, 1, "R7 steady visible in phase 2");
        // start with simultaneous param
        cmd_start = 1; prm_valid = 1; prm_data = 8'h03; cyc(1);
        cmd_start = 0; prm_valid = 0; cyc(1);
        check(row_last == 7, "R10 param with start ignored", row_last, 7);
        draw_at(3, 1, "R10 enable kept");
        // disable
        prm(8'h07);
        draw_at(3, 0, "R2 cursor disabled");
        // BR zero -> 32 -> 64 frames
        do_reset();
        start_cmd(); prm(8'h87); prm(8'h02); prm(8'h28);
        ticks(63);
        check(blink_phase == 0, "R4 zero rate 63 frames", blink_phase, 0);
        ticks(1);
        check(blink_phase == 1, "R4 zero rate 64 frames", blink_phase, 1);
        // overflow clear
        ticks(40);
        start_cmd(); prm(8'h87); prm(8'h42); prm(8'h28);
        ticks(23);
        check(blink_phase == 1, "R6 counting above period", blink_phase, 1);
        ticks(1);
        check(blink_phase == 1, "R6 clear at 64 no advance", blink_phase, 1);
        ticks(2);
        check(blink_phase == 2, "R6 resumes after clear", blink_phase, 2);
        cyc(3);
      end
      begin
        cyc(20000);
        fails++; tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule